// File: doc/BRIEF.md
# Instrument Bus Byte Handshake Engine

This block carries single bytes across an 8-bit parallel instrument bus that uses three open-collector handshake lines: data valid, not ready for data and not data accepted. It can play both roles in a transfer. As the sender it places a byte on the data lines, waits a programmable settle interval, asserts data valid, and holds it until the receivers report acceptance. As the receiver it signals readiness, captures the byte when data valid appears, and reports acceptance. The bus is modelled as active-low wired-AND. Every output is a pull-down enable, and every input is the resolved line level. A data bit of 1 pulls its line low.

The host sees two independent byte registers. One holds the byte to send, the other holds the last byte received. A send-ready flag and a receive-ready flag pace the host, so it writes only when the sender can take a byte and reads only when a byte has arrived. The sender can mark a byte as the last of a message with the end line, and the receiver reports that mark as an end flag. A no-listener error is raised when a byte is about to be sent and no receiver is holding the handshake lines.

The sender state machine moves through these states:
- Idle to WaitByte when its enable holds.
- WaitByte to Settle once a byte is pending.
- Settle to WaitRfd after the settle count.
- WaitRfd back to WaitByte on a no-listener error.
- WaitRfd to Dav when not-ready-for-data is released.
- Dav to WaitByte when not-data-accepted is released.
- Any state to Idle when the enable drops.

The receiver state machine moves through these states:
- Idle to Ready, or to Hold when the held byte is still unread.
- Ready to Accept when data valid is seen.
- Accept to Hold when data valid is released.
- Hold to Ready after the host has read the byte.
- Any state to Idle when the enable drops.

Top module: `gph_handshake`

## Requirements
- R1: The sender drives the byte for at least SETTLE_CYC cycles before it asserts data valid. When a receiver is ready, data valid is asserted exactly SETTLE_CYC+2 clock edges after the edge that accepts the host write.
- R2: The sender holds data valid while not-data-accepted is held low. One edge after that line is released, the sender releases data valid, the data lines and the end line. It does not offer the next byte until not-ready-for-data is high.
- R3: send_rdy is 1 only when the sender is active and waiting, holds no pending byte, and sees not-ready-for-data high. It clears one edge after an accepted write. A write made while send_rdy is 0 is ignored.
- R4: A receiver in the ready state pulls not-data-accepted and releases not-ready-for-data. On the first edge with data valid low, it does four things: it latches the inverted data lines (line low = bit 1), sets recv_rdy, releases not-data-accepted and pulls not-ready-for-data. After data valid rises, it pulls both lines until the host reads.
- R5: recv_rdy clears on the edge of a host read. The received byte stays unchanged while recv_rdy is set.
- R6: A byte written with tx_last high is driven with the end line pulled. recv_end takes the end line's state at the latch edge and clears on a host read.
- R7: Writing the send register never changes rx_byte. Reading never changes the data lines or data valid.
- R8: This requirement covers the case where, after settling, both not-ready-for-data and not-data-accepted are high. On that edge, talk_err is set, the byte is dropped and data valid is never asserted. talk_err clears on the next accepted write.
- R9: The sender is active only while talk_en or talk_only is 1, the attention line is high and the clear line is high. In talk-only mode the sender comes up one edge after attention is released and then raises send_rdy.
- R10: A low interface-clear line returns both state machines to Idle. It drops any pending byte and clears recv_rdy, recv_end and talk_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| talk_en | input | 1 | Sender addressed |
| listen_en | input | 1 | Receiver addressed |
| talk_only | input | 1 | Sender active without addressing |
| atn_n | input | 1 | Resolved attention line |
| ifc_n | input | 1 | Resolved interface-clear line |
| tx_wr | input | 1 | Host write strobe for the send register |
| tx_byte | input | 8 | Byte to send |
| tx_last | input | 1 | Send the byte with the end line |
| rx_rd | input | 1 | Host read strobe |
| rx_byte | output | 8 | Last received byte |
| send_rdy | output | 1 | Sender can take a byte |
| recv_rdy | output | 1 | Received byte waiting |
| recv_end | output | 1 | Received byte carried the end line |
| talk_err | output | 1 | No-listener error |
| dio_n | input | 8 | Resolved data lines |
| dio_pull | output | 8 | Data line pull-downs |
| dav_n | input | 1 | Resolved data valid |
| dav_pull | output | 1 | Data valid pull-down |
| nrfd_n | input | 1 | Resolved not-ready-for-data |
| nrfd_pull | output | 1 | Not-ready-for-data pull-down |
| ndac_n | input | 1 | Resolved not-data-accepted |
| ndac_pull | output | 1 | Not-data-accepted pull-down |
| eoi_n | input | 1 | Resolved end line |
| eoi_pull | output | 1 | End line pull-down |

## Verification
Data valid is due SETTLE_CYC+2 edges after an accepted write, and a no-listener error is due after the same count. The bench counts falling edges from the write and compares the count against that exact number. The receiver's flags and line pulls change one edge after data valid falls, and one edge after a read. send_rdy follows not-ready-for-data in the same cycle, and it rises one edge after attention is released. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check lands in the cycle worked out from the register count. All 256 byte values go through a loopback of the sender into the receiver, with the end line on every sixteenth byte.

// File: rtl/gph_pkg.sv
package gph_pkg;

    typedef enum logic [2:0] {
        TK_IDLE,
        TK_WAIT_BYTE,
        TK_SETTLE,
        TK_WAIT_RFD,
        TK_DAV
    } talk_state_e;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_HOLD,
        LS_READY,
        LS_ACCEPT
    } lsn_state_e;

endpackage

// File: rtl/gph_talker.sv
module gph_talker
    import gph_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SETTLE_CYC = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             clr,
    input  logic             nrfd_n,
    input  logic             ndac_n,
    input  logic             tx_wr,
    input  logic [WIDTH-1:0] tx_byte,
    input  logic             tx_last,
    output logic [WIDTH-1:0] dio_pull,
    output logic             dav_pull,
    output logic             eoi_pull,
    output logic             send_rdy,
    output logic             talk_err
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SETTLE_CYC);

    talk_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] dout_q;
    logic             last_q;
    logic             pend_q;
    logic             err_q;
    logic             wr_ok;
    logic             drive;
    logic             no_lsn;

    assign wr_ok  = tx_wr && send_rdy;
    assign no_lsn = nrfd_n && ndac_n;

    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = TK_IDLE;
        end else begin
            unique case (state_q)
                TK_IDLE:      state_d = TK_WAIT_BYTE;
                TK_WAIT_BYTE: if (pend_q) state_d = TK_SETTLE;
                TK_SETTLE:    if (cnt_q == LAST_CNT) state_d = TK_WAIT_RFD;
                TK_WAIT_RFD: begin
                    if (no_lsn)      state_d = TK_WAIT_BYTE;
                    else if (nrfd_n) state_d = TK_DAV;
                end
                TK_DAV:       if (ndac_n) state_d = TK_WAIT_BYTE;
                default:      state_d = TK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TK_IDLE;
            cnt_q   <= '0;
            dout_q  <= '0;
            last_q  <= 1'b0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == TK_SETTLE && state_d == TK_SETTLE) ? cnt_q + 1'b1 : '0;
            if (wr_ok) begin
                dout_q <= tx_byte;
                last_q <= tx_last;
            end
            if (clr)
                pend_q <= 1'b0;
            else if (wr_ok)
                pend_q <= 1'b1;
            else if ((state_q == TK_WAIT_RFD || state_q == TK_DAV) && state_d == TK_WAIT_BYTE)
                pend_q <= 1'b0;
            if (clr || wr_ok)
                err_q <= 1'b0;
            else if (go && state_q == TK_WAIT_RFD && no_lsn)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        drive    = (state_q == TK_SETTLE) || (state_q == TK_WAIT_RFD) || (state_q == TK_DAV);
        dio_pull = drive ? dout_q : '0;
        eoi_pull = drive && last_q;
        dav_pull = (state_q == TK_DAV);
        send_rdy = (state_q == TK_WAIT_BYTE) && !pend_q && nrfd_n;
        talk_err = err_q;
    end

    logic [CNT_W-1:0] dwell_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dwell_q <= '0;
        else if (!drive)           dwell_q <= '0;
        else if (dwell_q != FULL_CNT) dwell_q <= dwell_q + 1'b1;
    end

    // R1: data has dwelt on the lines for the settle interval before DAV
    a_r1_settle_before_dav: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav_pull) |-> (dwell_q == FULL_CNT));

    // R2: DAV stays while the receiver has not accepted
    a_r2_dav_held: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_pull && !ndac_n && go) |=> dav_pull);

    // R3: send-ready implies the ready line is released
    a_r3_ready_needs_rfd: assert property (@(posedge clk) disable iff (!rst_n)
        send_rdy |-> nrfd_n);

    // R8: an errored byte never reaches DAV
    a_r8_err_no_dav: assert property (@(posedge clk) disable iff (!rst_n)
        talk_err |-> !dav_pull);

    // R6: end line only accompanies a driven byte
    a_r6_eoi_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pull |-> !send_rdy);

endmodule

// File: rtl/gph_listener.sv
module gph_listener
    import gph_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             clr,
    input  logic             dav_n,
    input  logic             eoi_n,
    input  logic [WIDTH-1:0] dio_n,
    input  logic             rx_rd,
    output logic             nrfd_pull,
    output logic             ndac_pull,
    output logic [WIDTH-1:0] rx_byte,
    output logic             recv_rdy,
    output logic             recv_end
);

    lsn_state_e       state_q, state_d;
    logic [WIDTH-1:0] din_q;
    logic             full_q;
    logic             end_q;
    logic             take;

    assign take = go && (state_q == LS_READY) && !dav_n;

    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = LS_IDLE;
        end else begin
            unique case (state_q)
                LS_IDLE:   state_d = full_q ? LS_HOLD : LS_READY;
                LS_HOLD:   if (!full_q) state_d = LS_READY;
                LS_READY:  if (!dav_n) state_d = LS_ACCEPT;
                LS_ACCEPT: if (dav_n) state_d = LS_HOLD;
                default:   state_d = LS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            din_q   <= '0;
            full_q  <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take)
                din_q <= ~dio_n;
            if (clr) begin
                full_q <= 1'b0;
                end_q  <= 1'b0;
            end else if (take) begin
                full_q <= 1'b1;
                end_q  <= !eoi_n;
            end else if (rx_rd) begin
                full_q <= 1'b0;
                end_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        ndac_pull = (state_q == LS_HOLD) || (state_q == LS_READY);
        nrfd_pull = (state_q == LS_HOLD) || (state_q == LS_ACCEPT);
        rx_byte   = din_q;
        recv_rdy  = full_q;
        recv_end  = end_q;
    end

    // R4: an addressed receiver always holds at least one handshake line
    a_r4_holds_a_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(go) && go) |-> (nrfd_pull || ndac_pull));

    // R4: a byte is only taken while DAV was low
    a_r4_latch_on_dav: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recv_rdy) |-> $past(!dav_n));

    // R5: the held byte does not move while it is waiting
    a_r5_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (recv_rdy && $past(recv_rdy)) |-> $stable(rx_byte));

endmodule

// File: rtl/gph_handshake.sv
module gph_handshake
    import gph_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int SETTLE_CYC = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             talk_en,
    input  logic             listen_en,
    input  logic             talk_only,
    input  logic             atn_n,
    input  logic             ifc_n,
    input  logic             tx_wr,
    input  logic [WIDTH-1:0] tx_byte,
    input  logic             tx_last,
    input  logic             rx_rd,
    output logic [WIDTH-1:0] rx_byte,
    output logic             send_rdy,
    output logic             recv_rdy,
    output logic             recv_end,
    output logic             talk_err,
    input  logic [WIDTH-1:0] dio_n,
    output logic [WIDTH-1:0] dio_pull,
    input  logic             dav_n,
    output logic             dav_pull,
    input  logic             nrfd_n,
    output logic             nrfd_pull,
    input  logic             ndac_n,
    output logic             ndac_pull,
    input  logic             eoi_n,
    output logic             eoi_pull
);

    logic talk_go;
    logic lsn_go;
    logic clr;

    assign clr     = !ifc_n;
    assign talk_go = (talk_en || talk_only) && atn_n && ifc_n;
    assign lsn_go  = listen_en && ifc_n;

    gph_talker #(
        .WIDTH      (WIDTH),
        .SETTLE_CYC (SETTLE_CYC)
    ) talker_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (talk_go),
        .clr      (clr),
        .nrfd_n   (nrfd_n),
        .ndac_n   (ndac_n),
        .tx_wr    (tx_wr),
        .tx_byte  (tx_byte),
        .tx_last  (tx_last),
        .dio_pull (dio_pull),
        .dav_pull (dav_pull),
        .eoi_pull (eoi_pull),
        .send_rdy (send_rdy),
        .talk_err (talk_err)
    );

    gph_listener #(
        .WIDTH (WIDTH)
    ) listener_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (lsn_go),
        .clr       (clr),
        .dav_n     (dav_n),
        .eoi_n     (eoi_n),
        .dio_n     (dio_n),
        .rx_rd     (rx_rd),
        .nrfd_pull (nrfd_pull),
        .ndac_pull (ndac_pull),
        .rx_byte   (rx_byte),
        .recv_rdy  (recv_rdy),
        .recv_end  (recv_end)
    );

    // R10: interface clear silences every line on the next edge
    a_r10_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ifc_n |=> !(dav_pull || nrfd_pull || ndac_pull || eoi_pull));

endmodule

// File: tb/gph_handshake_tb_top.sv
module gph_handshake_tb_top;

    localparam int SETTLE = 17;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       talk_en, listen_en, talk_only;
    logic       tb_atn, tb_ifc;
    logic       tx_wr, tx_last, rx_rd;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       send_rdy, recv_rdy, recv_end, talk_err;
    logic [7:0] dio_pull, tb_dio;
    logic       dav_pull, nrfd_pull, ndac_pull, eoi_pull;
    logic       tb_dav, tb_nrfd, tb_ndac, tb_eoi;
    logic [7:0] dio_n;
    logic       dav_n, nrfd_n, ndac_n, eoi_n;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign dio_n  = ~(dio_pull | tb_dio);
    assign dav_n  = ~(dav_pull | tb_dav);
    assign nrfd_n = ~(nrfd_pull | tb_nrfd);
    assign ndac_n = ~(ndac_pull | tb_ndac);
    assign eoi_n  = ~(eoi_pull | tb_eoi);

    gph_handshake #(.WIDTH(8), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .talk_en(talk_en), .listen_en(listen_en),
        .talk_only(talk_only), .atn_n(!tb_atn), .ifc_n(!tb_ifc),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_last(tx_last), .rx_rd(rx_rd),
        .rx_byte(rx_byte), .send_rdy(send_rdy), .recv_rdy(recv_rdy),
        .recv_end(recv_end), .talk_err(talk_err),
        .dio_n(dio_n), .dio_pull(dio_pull), .dav_n(dav_n), .dav_pull(dav_pull),
        .nrfd_n(nrfd_n), .nrfd_pull(nrfd_pull), .ndac_n(ndac_n), .ndac_pull(ndac_pull),
        .eoi_n(eoi_n), .eoi_pull(eoi_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, input logic last);
        tx_byte = b; tx_last = last; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_byte();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic bench_send(input logic [7:0] b, input logic e);
        tb_dio = b; tb_eoi = e;
        @(negedge clk);
        tb_dav = 1'b1;
        @(negedge clk);
        tb_dav = 1'b0; tb_dio = '0; tb_eoi = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int c;
        bit seen;
        rst_n = 0; talk_en = 0; listen_en = 0; talk_only = 0;
        tb_atn = 0; tb_ifc = 0; tx_wr = 0; tx_last = 0; rx_rd = 0; tx_byte = '0;
        tb_dio = '0; tb_dav = 0; tb_nrfd = 0; tb_ndac = 0; tb_eoi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk(!send_rdy && !recv_rdy && !talk_err, "R3 reset flags", {send_rdy, recv_rdy, talk_err}, 0);
        chk(!dav_pull && !nrfd_pull && !ndac_pull && dio_pull == 0, "R4 reset lines", {dav_pull, nrfd_pull, ndac_pull}, 0);

        // receiver driven by bench sender
        listen_en = 1;
        @(negedge clk);
        chk(ndac_pull && !nrfd_pull, "R4 ready lines", {nrfd_pull, ndac_pull}, 1);
        tb_dio = 8'hA5; tb_eoi = 1;
        @(negedge clk);
        tb_dav = 1;
        @(negedge clk);
        chk(recv_rdy, "R4 byte flagged", recv_rdy, 1);
        chk(rx_byte == 8'hA5, "R4 byte latched", rx_byte, 8'hA5);
        chk(recv_end, "R6 end received", recv_end, 1);
        chk(nrfd_pull && !ndac_pull, "R4 accept lines", {nrfd_pull, ndac_pull}, 2);
        tb_dav = 0; tb_eoi = 0; tb_dio = '0;
        @(negedge clk);
        chk(nrfd_pull && ndac_pull && recv_rdy, "R4 hold lines", {nrfd_pull, ndac_pull}, 3);
        read_byte();
        chk(!recv_rdy, "R5 read clears flag", recv_rdy, 0);
        chk(!recv_end, "R6 read clears end", recv_end, 0);
        chk(rx_byte == 8'hA5, "R5 byte kept", rx_byte, 8'hA5);
        @(negedge clk);
        chk(!nrfd_pull && ndac_pull, "R4 ready again", {nrfd_pull, ndac_pull}, 1);

        // interface clear on receiver
        bench_send(8'h3C, 0);
        chk(recv_rdy && !recv_end, "R6 no end", {recv_rdy, recv_end}, 2);
        tb_ifc = 1;
        @(negedge clk);
        tb_ifc = 0;
        chk(!recv_rdy && !nrfd_pull && !ndac_pull, "R10 receiver cleared", {recv_rdy, nrfd_pull, ndac_pull}, 0);
        @(negedge clk);
        bench_send(8'h3C, 0);
        listen_en = 0;
        @(negedge clk);

        // data registers are independent, no-listener error
        talk_en = 1;
        @(negedge clk);
        chk(send_rdy, "R3 ready when idle", send_rdy, 1);
        write_byte(8'hC3, 0);
        chk(rx_byte == 8'h3C && recv_rdy, "R7 write keeps rx", rx_byte, 8'h3C);
        chk(!send_rdy, "R3 clears after write", send_rdy, 0);
        c = 0; seen = 0;
        while (!talk_err && c < 100) begin
            @(negedge clk); c++;
            if (dav_pull) seen = 1;
        end
        chk(c == SETTLE + 2, "R8 error timing", c, SETTLE + 2);
        chk(!seen, "R8 no DAV", seen, 0);
        chk(send_rdy, "R8 byte dropped", send_rdy, 1);

        // handshake against bench receiver
        tb_ndac = 1;
        write_byte(8'h5A, 1);
        chk(!talk_err, "R8 error cleared by write", talk_err, 0);
        c = 0;
        while (!dav_pull && c < 100) begin
            @(negedge clk); c++;
        end
        chk(c == SETTLE + 2, "R1 DAV latency", c, SETTLE + 2);
        chk(dio_pull == 8'h5A, "R1 byte on lines", dio_pull, 8'h5A);
        chk(eoi_pull, "R6 end with byte", eoi_pull, 1);
        repeat (3) @(negedge clk);
        chk(dav_pull, "R2 DAV held", dav_pull, 1);
        read_byte();
        chk(dav_pull && dio_pull == 8'h5A, "R7 read keeps lines", dio_pull, 8'h5A);
        tb_nrfd = 1; tb_ndac = 0;
        @(negedge clk);
        chk(!dav_pull && dio_pull == 0 && !eoi_pull, "R2 release", {dav_pull, eoi_pull}, 0);
        chk(!send_rdy, "R2 waits for RFD", send_rdy, 0);
        tb_nrfd = 0;
        #1;
        chk(send_rdy, "R3 ready on RFD", send_rdy, 1);
        @(negedge clk);

        // ignored write
        talk_en = 0;
        @(negedge clk);
        write_byte(8'h77, 0);
        talk_en = 1;
        @(negedge clk);
        chk(send_rdy, "R3 ignored write", send_rdy, 1);
        repeat (SETTLE + 4) @(negedge clk);
        chk(!talk_err && dio_pull == 0, "R3 nothing sent", dio_pull, 0);

        // attention and talk-only
        tb_atn = 1;
        @(negedge clk);
        chk(!send_rdy, "R9 attention stops sender", send_rdy, 0);
        tb_atn = 0;
        @(negedge clk);
        chk(send_rdy, "R9 sender back", send_rdy, 1);
        talk_en = 0; talk_only = 1; tb_atn = 1; tb_ifc = 1;
        @(negedge clk);
        tb_ifc = 0;
        @(negedge clk);
        chk(!send_rdy, "R9 talk-only waits", send_rdy, 0);
        tb_atn = 0;
        #1;
        chk(!send_rdy, "R9 not yet", send_rdy, 0);
        @(negedge clk);
        chk(send_rdy, "R9 talk-only up", send_rdy, 1);
        talk_only = 0; talk_en = 1;

        // interface clear on sender
        tb_ndac = 1;
        write_byte(8'hE1, 0);
        while (!dav_pull) @(negedge clk);
        tb_ifc = 1;
        @(negedge clk);
        tb_ifc = 0;
        chk(!dav_pull && dio_pull == 0, "R10 sender cleared", dio_pull, 0);
        @(negedge clk);
        chk(send_rdy, "R10 pending dropped", send_rdy, 1);
        @(negedge clk);
        chk(dio_pull == 0, "R10 nothing resent", dio_pull, 0);
        tb_ndac = 0;

        // loopback of every byte value
        listen_en = 1;
        read_byte();
        repeat (2) @(negedge clk);
        for (int b = 0; b < 256; b++) begin
            logic lst;
            lst = (b % 16 == 15);
            while (!send_rdy) @(negedge clk);
            write_byte(8'(b), lst);
            c = 0;
            while (!dav_pull && c < 100) begin
                @(negedge clk); c++;
            end
            chk(c == SETTLE + 2, "R1 loop latency", c, SETTLE + 2);
            chk(dio_pull == 8'(b), "R1 loop lines", dio_pull, b);
            while (!recv_rdy) @(negedge clk);
            chk(rx_byte == 8'(b), "R4 loop byte", rx_byte, b);
            chk(recv_end == lst, "R6 loop end", recv_end, lst);
            read_byte();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule